// File: doc/BRIEF.md
# Banked External Interrupt Controller

The block watches a wide group of external input pins, split into banks of up to 32 lines each. Every line has its own trigger condition: rising edge, falling edge, both edges, high level or low level. When the condition is seen, a sticky pending bit is recorded for that line. A single interrupt request goes high while any pending line is also enabled. Software configures and services the block through a simple word-wide register write/read port that shares its address space with the pin-control block next to it.

Pins are first brought into the clock domain through a short synchronizer. Each bank then samples them at a rate set by that bank's own sampling configuration. The base tick is either the core clock or an external slow tick pulse. A power-of-two prescaler divides that base tick down to the sampling strobe. Edges are found by comparing two consecutive samples. Level conditions set the pending bit again on every strobe for as long as the level lasts. Software acknowledges a bank's lines by writing ones to its pending word. It may write back the whole word it has just read.

Top module: `ext_irq_banks`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The trigger code of line k in bank b is a 4-bit field at bits 4*(k mod 8)+3 down to 4*(k mod 8) of the word at byte address 0x200 + 0x20*b + 4*(k div 8). The field reads back as written.
- R3: The enable word of bank b is at 0x210 + 0x20*b, with bit k enabling line k. It reads back as written.
- R4: On a sampling strobe a line sets its pending bit according to its code. Code 0 sets on a 0-to-1 change between the previous and the current sample. Code 1 sets on a 1-to-0 change. Code 2 sets while the sample is 1. Code 3 sets while the sample is 0. Code 4 sets on any change.
- R5: The pending word of bank b is at 0x214 + 0x20*b. Writing 1 to a bit clears it, and writing 0 leaves it unchanged, so writing back a word just read clears exactly those bits.
- R6: If a line's condition is detected in the same cycle its pending bit is cleared by a write, the bit stays set. A held level therefore sets the bit again straight after every clear.
- R7: The sampling word of bank b is at 0x218 + 0x20*b. Bit 0 picks the base tick: 0 is every clock, 1 is the `slow_tick` input. Bits 6:4 hold an exponent e, and the strobe fires once every 2^e base ticks. All other bits read zero. Writing this word restarts the bank's tick count.
- R8: Codes 5 to 15 never set a pending bit.
- R9: Pending bits latch whether or not the line is enabled. `irq` is high exactly when some bank has a line that is both pending and enabled.
- R10: With e = 0 and the clock as base tick, a pin change driven before a clock edge shows in the pending bit and `irq` after the third following rising edge: two synchronizer stages, then the detecting strobe.
- R11: Addresses that decode to no register read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_BANKS*LINES | Asynchronous external pin levels, bank b at bits b*LINES upward |
| slow_tick | input | 1 | One-cycle pulse used as the alternative base tick |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The interesting coincidence is a pending-bit set from the trigger logic and a write-one-to-clear from software landing on the same clock edge. The bench provokes it by holding a high-level line high while it writes the bank's pending word with that bit set, and at other times by random pending-word writes during dense random pin activity. A behavioural reference model with its own synchronizer, prescaler and pending state is stepped on every edge. The read data and `irq` are compared against it every cycle, so any edge where set and clear meet is judged by the rule that the set wins.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int REG_W          = 32;
    localparam int MODE_W         = 4;
    localparam int LINES_PER_WORD = 8;
    localparam int MODE_BASE      = 32'h200;
    localparam int BANK_STRIDE    = 32'h20;
    localparam int DBC_EXP_W      = 3;
    localparam int DBC_EXP_LSB    = 4;

    // trigger codes; any other value is inert
    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

    typedef struct packed {
        logic [DBC_EXP_W-1:0] exp;
        logic                 src_slow;
    } dbc_cfg_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_MODE,
        RK_EN,
        RK_STAT,
        RK_DBC
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] word;
    } reg_sel_t;

    // condition test between previous and current sample
    function automatic logic trig_hit(logic [MODE_W-1:0] mode, logic prev, logic cur);
        logic r;
        case (mode)
            TRIG_RISE: r = !prev && cur;
            TRIG_FALL: r = prev && !cur;
            TRIG_HIGH: r = cur;
            TRIG_LOW:  r = !cur;
            TRIG_BOTH: r = prev ^ cur;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    // offset within one bank's window to register selection
    function automatic reg_sel_t decode_ofs(logic [4:0] ofs, int unsigned words);
        reg_sel_t r;
        r.kind = RK_NONE;
        r.word = ofs[3:2];
        if (ofs[1:0] == 2'b00) begin
            if (!ofs[4]) begin
                if (int'(ofs[3:2]) < int'(words)) r.kind = RK_MODE;
            end else begin
                case (ofs[3:2])
                    2'd0:    r.kind = RK_EN;
                    2'd1:    r.kind = RK_STAT;
                    2'd2:    r.kind = RK_DBC;
                    default: r.kind = RK_NONE;
                endcase
            end
        end
        return r;
    endfunction

    function automatic logic [REG_W-1:0] dbc_pack(dbc_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[0] = c.src_slow;
        w[DBC_EXP_LSB +: DBC_EXP_W] = c.exp;
        return w;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/eirq_strobe.sv
module eirq_strobe #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_tick,
    input  logic             restart,
    input  logic [EXP_W-1:0] exp,
    output logic             strobe
);
    localparam int CNT_W = (1 << EXP_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit  = CNT_W'((32'd1 << exp) - 32'd1);
    assign strobe = base_tick && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (base_tick) cnt <= strobe ? '0 : cnt + 1'b1;
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);
endmodule

// File: rtl/eirq_bank.sv
module eirq_bank
    import eirq_pkg::*;
#(
    parameter int LINES       = 32,
    parameter int EXP_W       = DBC_EXP_W,
    parameter int SYNC_STAGES = 2,
    localparam int MODE_WORDS = (LINES + LINES_PER_WORD - 1) / LINES_PER_WORD
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LINES-1:0]            pins,
    input  logic                        slow_tick,
    input  logic [MODE_WORDS-1:0]       wr_mode,
    input  logic                        wr_en,
    input  logic                        wr_stat,
    input  logic                        wr_dbc,
    input  logic [REG_W-1:0]            wdata,
    output logic [MODE_WORDS*REG_W-1:0] rd_mode,
    output logic [REG_W-1:0]            rd_en,
    output logic [REG_W-1:0]            rd_stat,
    output logic [REG_W-1:0]            rd_dbc,
    output logic                        irq_out
);
    logic [MODE_W-1:0] mode_r [LINES];
    logic [LINES-1:0]  en_r;
    logic [LINES-1:0]  stat_r;
    logic [LINES-1:0]  samp_r;
    logic [LINES-1:0]  sync_q;
    logic [LINES-1:0]  hit;
    logic [LINES-1:0]  clr;
    dbc_cfg_t          dbc_r;
    logic              strobe;
    logic              base_tick;

    eirq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins),
        .q   (sync_q)
    );

    assign base_tick = dbc_r.src_slow ? slow_tick : 1'b1;

    eirq_strobe #(.EXP_W(EXP_W)) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .restart   (wr_dbc),
        .exp       (dbc_r.exp),
        .strobe    (strobe)
    );

    genvar k;
    generate
        for (k = 0; k < LINES; k++) begin : g_line
            assign hit[k] = strobe && trig_hit(mode_r[k], samp_r[k], sync_q[k]);

            always_ff @(posedge clk) begin
                if (rst) mode_r[k] <= '0;
                else if (wr_mode[k / LINES_PER_WORD])
                    mode_r[k] <= wdata[(k % LINES_PER_WORD) * MODE_W +: MODE_W];
            end

            // R4
            rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
                (strobe && mode_r[k] == TRIG_RISE && !samp_r[k] && sync_q[k]) |=> stat_r[k]);

            // R6
            level_sets_chk: assert property (@(posedge clk) disable iff (rst)
                (strobe && mode_r[k] == TRIG_HIGH && sync_q[k]) |=> stat_r[k]);

            // R8
            inert_code_chk: assert property (@(posedge clk) disable iff (rst)
                (!stat_r[k] && mode_r[k] > 4'd4) |=> !stat_r[k]);
        end
    endgenerate

    assign clr = wr_stat ? wdata[LINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_r   <= '0;
            stat_r <= '0;
            samp_r <= '0;
            dbc_r  <= '0;
        end else begin
            stat_r <= (stat_r & ~clr) | hit;
            if (strobe) samp_r <= sync_q;
            if (wr_en)  en_r   <= wdata[LINES-1:0];
            if (wr_dbc) begin
                dbc_r.src_slow <= wdata[0];
                dbc_r.exp      <= wdata[DBC_EXP_LSB +: EXP_W];
            end
        end
    end

    always_comb begin
        rd_mode = '0;
        for (int i = 0; i < LINES; i++) rd_mode[i*MODE_W +: MODE_W] = mode_r[i];
    end

    assign rd_en   = REG_W'(en_r);
    assign rd_stat = REG_W'(stat_r);
    assign rd_dbc  = dbc_pack(dbc_r);
    assign irq_out = |(stat_r & en_r);

    // R5
    stat_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> ((stat_r & $past(wdata[LINES-1:0]) & ~$past(hit)) == '0));
endmodule

// File: rtl/ext_irq_banks.sv
module ext_irq_banks
    import eirq_pkg::*;
#(
    parameter int NUM_BANKS   = 5,
    parameter int LINES       = 32,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int EXP_W       = DBC_EXP_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_BANKS*LINES-1:0] pin_in,
    input  logic                       slow_tick,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    output logic                       irq
);
    localparam int MODE_WORDS = (LINES + LINES_PER_WORD - 1) / LINES_PER_WORD;

    logic [REG_W-1:0]     bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    genvar b, w;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            localparam logic [ADDR_W-1:0] BASE = ADDR_W'(MODE_BASE + b * BANK_STRIDE);

            logic                        in_bank;
            reg_sel_t                    sel;
            logic [MODE_WORDS-1:0]       wr_mode;
            logic [MODE_WORDS*REG_W-1:0] m_rd;
            logic [REG_W-1:0]            e_rd, s_rd, d_rd;
            logic [REG_W-1:0]            rd_b;

            assign in_bank = (reg_addr >= BASE) &&
                             (reg_addr < BASE + ADDR_W'(BANK_STRIDE));
            assign sel = in_bank ? decode_ofs(5'(reg_addr - BASE), MODE_WORDS)
                                 : '{kind: RK_NONE, word: 2'd0};

            for (w = 0; w < MODE_WORDS; w++) begin : g_wsel
                assign wr_mode[w] = reg_we && sel.kind == RK_MODE && sel.word == 2'(w);
            end

            eirq_bank #(
                .LINES       (LINES),
                .EXP_W       (EXP_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_bank (
                .clk       (clk),
                .rst       (rst),
                .pins      (pin_in[b*LINES +: LINES]),
                .slow_tick (slow_tick),
                .wr_mode   (wr_mode),
                .wr_en     (reg_we && sel.kind == RK_EN),
                .wr_stat   (reg_we && sel.kind == RK_STAT),
                .wr_dbc    (reg_we && sel.kind == RK_DBC),
                .wdata     (reg_wdata),
                .rd_mode   (m_rd),
                .rd_en     (e_rd),
                .rd_stat   (s_rd),
                .rd_dbc    (d_rd),
                .irq_out   (bank_irq[b])
            );

            always_comb begin
                case (sel.kind)
                    RK_MODE: rd_b = m_rd[REG_W*sel.word +: REG_W];
                    RK_EN:   rd_b = e_rd;
                    RK_STAT: rd_b = s_rd;
                    RK_DBC:  rd_b = d_rd;
                    default: rd_b = '0;
                endcase
            end

            assign bank_rd[b] = rd_b;
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) reg_rdata |= bank_rd[i];
    end

    assign irq = |bank_irq;

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> !irq);

    // R11
    below_window_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < ADDR_W'(MODE_BASE)) |-> (reg_rdata == '0));
endmodule

// File: tb/tb_ext_irq_banks.sv
module tb_ext_irq_banks;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 5;
    localparam int NL = 32;
    localparam int NP = NB * NL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic          slow_tick = 1'b0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int compared = 0;
    int mismatched = 0;
    int tick_ctr = 0;
    bit rand_tick = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_banks dut (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pins),
        .slow_tick (slow_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // ---------------- behavioural reference ----------------
    logic [3:0]  m_mode [NB][NL];
    logic [31:0] m_en [NB], m_stat [NB], m_s1 [NB], m_s2 [NB], m_samp [NB];
    logic        m_src [NB];
    int          m_exp [NB], m_cnt [NB];
    int          mb_lim;
    logic        mb_base, mb_strobe, mb_prev, mb_cur, mb_hit;
    logic [31:0] mb_set, mb_clr;

    function automatic bit addr_split(int a, output int bk, output int of);
        bk = 0; of = 0;
        if (a < 'h200) return 0;
        bk = (a - 'h200) / 32;
        of = (a - 'h200) % 32;
        if (bk >= NB) return 0;
        if (of % 4 != 0) return 0;
        if (of >= 'h1C) return 0;
        return 1;
    endfunction

    function automatic logic [31:0] m_read(int a);
        int bk, of;
        logic [31:0] v;
        v = '0;
        if (addr_split(a, bk, of)) begin
            if (of < 16) begin
                for (int j = 0; j < 8; j++) v[j*4 +: 4] = m_mode[bk][(of/4)*8 + j];
            end else if (of == 16) v = m_en[bk];
            else if (of == 20) v = m_stat[bk];
            else begin
                v[0] = m_src[bk];
                v[6:4] = 3'(m_exp[bk]);
            end
        end
        return v;
    endfunction

    function automatic string tag_for(int a);
        int bk, of;
        if (!addr_split(a, bk, of)) return "R11";
        if (of < 16) return "R2";
        if (of == 16) return "R3";
        if (of == 20) return "R5";
        return "R7";
    endfunction

    function automatic logic m_irq();
        logic r;
        r = 1'b0;
        for (int b = 0; b < NB; b++) r |= |(m_stat[b] & m_en[b]);
        return r;
    endfunction

    always @(posedge clk) begin
        int wb, wo;
        bit wv;
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                for (int k = 0; k < NL; k++) m_mode[b][k] = 4'd0;
                m_en[b] = 0; m_stat[b] = 0; m_s1[b] = 0; m_s2[b] = 0; m_samp[b] = 0;
                m_src[b] = 0; m_exp[b] = 0; m_cnt[b] = 0;
            end
        end else begin
            wv = reg_we && addr_split(int'(reg_addr), wb, wo);
            for (int b = 0; b < NB; b++) begin
                mb_base = m_src[b] ? slow_tick : 1'b1;
                mb_lim = (1 << m_exp[b]) - 1;
                mb_strobe = mb_base && (m_cnt[b] >= mb_lim);
                mb_set = 0;
                if (mb_strobe) begin
                    for (int k = 0; k < NL; k++) begin
                        mb_prev = m_samp[b][k];
                        mb_cur = m_s2[b][k];
                        case (m_mode[b][k])
                            4'd0: mb_hit = !mb_prev && mb_cur;
                            4'd1: mb_hit = mb_prev && !mb_cur;
                            4'd2: mb_hit = mb_cur;
                            4'd3: mb_hit = !mb_cur;
                            4'd4: mb_hit = mb_prev != mb_cur;
                            default: mb_hit = 1'b0;
                        endcase
                        mb_set[k] = mb_hit;
                    end
                end
                mb_clr = (wv && wb == b && wo == 20) ? reg_wdata : 32'd0;
                m_stat[b] = (m_stat[b] & ~mb_clr) | mb_set;
                if (mb_base) m_cnt[b] = mb_strobe ? 0 : m_cnt[b] + 1;
                if (mb_strobe) m_samp[b] = m_s2[b];
                m_s2[b] = m_s1[b];
                m_s1[b] = pins[b*NL +: NL];
            end
            if (wv) begin
                if (wo < 16) begin
                    for (int j = 0; j < 8; j++) m_mode[wb][(wo/4)*8 + j] = reg_wdata[j*4 +: 4];
                end else if (wo == 16) m_en[wb] = reg_wdata;
                else if (wo == 24) begin
                    m_src[wb] = reg_wdata[0];
                    m_exp[wb] = int'(reg_wdata[6:4]);
                    m_cnt[wb] = 0;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check("R9", 32'(irq), 32'(m_irq()));
        check(tag_for(int'(reg_addr)), reg_rdata, m_read(int'(reg_addr)));
        tick_ctr++;
        slow_tick = rand_tick ? 1'($urandom % 2) : (tick_ctr % 3 == 0);
    endtask

    task automatic cycn(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_addr = 12'(a); reg_wdata = d; reg_we = 1'b1;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic rd(int a);
        reg_addr = 12'(a);
        cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int n;
        cycn(4);
        rst = 1'b0;

        // R1: reset values
        rd('h200); check("R1", reg_rdata, 0);
        rd('h210); check("R1", reg_rdata, 0);
        rd('h214); check("R1", reg_rdata, 0);
        rd('h218); check("R1", reg_rdata, 0);
        rd('h290); check("R1", reg_rdata, 0);
        check("R1", 32'(irq), 0);

        // bank 0 setup: line0 rise, 1 fall, 2 high, 3 low, 4 both, 5 code 7
        pins[3] = 1'b1;
        wr('h200, 32'h0074_3210);
        wr('h204, 32'h0000_0001);
        wr('h210, 32'h0000_001F);
        rd('h200); check("R2", reg_rdata, 32'h0074_3210);
        rd('h210); check("R3", reg_rdata, 32'h0000_001F);
        cycn(4);
        wr('h214, 32'hFFFF_FFFF);
        check("R5", reg_rdata, 0);
        check("R9", 32'(irq), 0);

        // R10 latency and R4 rising edge
        pins[0] = 1'b1;
        cycn(2); check("R10", 32'(irq), 0);
        cyc();   check("R10", 32'(irq), 1);
        check("R4", reg_rdata, 32'h1);
        wr('h214, reg_rdata);
        check("R5", reg_rdata, 0);

        // R4 falling edge
        pins[1] = 1'b1; cycn(4); check("R4", reg_rdata, 0);
        pins[1] = 1'b0; cycn(4); check("R4", reg_rdata, 32'h2);
        wr('h214, 32'h2);

        // R4 both edges
        pins[4] = 1'b1; cycn(4); check("R4", reg_rdata, 32'h10);
        wr('h214, 32'h10); check("R5", reg_rdata, 0);
        pins[4] = 1'b0; cycn(4); check("R4", reg_rdata, 32'h10);
        wr('h214, 32'h10);

        // R8 inert code on line 5
        for (int i = 0; i < 4; i++) begin
            pins[5] = ~pins[5];
            cycn(3);
        end
        check("R8", reg_rdata, 0);

        // R9 disabled line latches, irq gated by enable
        pins[6] = 1'b1; cycn(4);
        check("R9", reg_rdata, 32'h40);
        check("R9", 32'(irq), 0);
        wr('h210, 32'h0000_005F);
        check("R9", 32'(irq), 1);

        // R5 partial clear, R6 set wins over clear
        pins[2] = 1'b1; cycn(4);
        rd('h214); check("R6", reg_rdata, 32'h44);
        wr('h214, 32'h40); check("R5", reg_rdata, 32'h4);
        wr('h214, 32'h4);  check("R6", reg_rdata, 32'h4);
        pins[2] = 1'b0; cycn(4);
        wr('h214, 32'hFFFF_FFFF); check("R5", reg_rdata, 0);

        // R7 sampling word fields and prescaled clock base
        wr('h238, 32'hFFFF_FFFF); check("R7", reg_rdata, 32'h71);
        wr('h238, 32'h0000_0020); check("R7", reg_rdata, 32'h20);
        reg_addr = 12'h234;
        pins[32] = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            cyc();
            if (reg_rdata[0]) begin n = i + 1; break; end
        end
        check("R7", 32'(n >= 3 && n <= 6), 1);

        // R7 slow tick base
        wr('h258, 32'h0000_0011); check("R7", reg_rdata, 32'h11);
        reg_addr = 12'h254;
        pins[64] = 1'b1;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            cyc();
            if (reg_rdata[0]) begin n = i + 1; break; end
        end
        check("R7", 32'(n >= 3 && n <= 12), 1);

        // R11 unmapped addresses
        wr('h100, 32'hFFFF_FFFF); check("R11", reg_rdata, 0);
        wr('h21C, 32'hFFFF_FFFF); check("R11", reg_rdata, 0);
        rd('h2A0); check("R11", reg_rdata, 0);
        rd('h202); check("R11", reg_rdata, 0);

        // random phase, compared against the model every cycle
        rand_tick = 1;
        for (int i = 0; i < 4000; i++) begin
            for (int b = 0; b < NB; b++)
                pins[b*NL +: NL] ^= ($urandom & $urandom & $urandom & $urandom);
            reg_addr  = 12'('h200 + 'h20 * ($urandom % 6) + 4 * ($urandom % 8));
            reg_wdata = $urandom;
            if (reg_addr[4:0] == 5'h18) reg_wdata = reg_wdata & 32'h31;
            reg_we = ($urandom % 6 == 0);
            cyc();
            reg_we = 1'b0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule